// File: doc/BRIEF.md
# Vectored Fixed-Priority Interrupt Controller

This block gathers 24 maskable interrupt request lines for a small processor core. A rising edge on any request line latches a pending flag for that source, whether or not the source is enabled. A master enable bit and one enable bit per source gate the flags. The per-source bits are held six to a register in four enable registers. Whenever the core signals the final cycle of an instruction, the block looks for an enabled pending source and picks the one with the lowest index. It then raises a one-cycle accept pulse with the source number and its 16-bit service address, and it clears the winner's flag.

Once a source is accepted, the block stays in service and makes no further acceptances until the core sends a return-from-interrupt pulse. Requests that arrive in the meantime stay latched. Software can load the enable registers through a simple write port. It can also drop pending flags through a clear port without servicing them. Stacking the program counter, running the instruction pipeline and choosing the polarity of external pins are left to the surrounding logic.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, `pending`, `in_service`, `accept` and all enable bits (master and per-source) are 0.
- R2: A 0-to-1 transition of `irq_req[k]` sets `pending[k]` one cycle later, whatever the enables are. A line held high sets the flag only once.
- R3: A source is accepted only when the master enable and its own enable are both 1. A write with `cfg_sel` = r (0..3) loads `cfg_wdata[b]` as the enable of source 6*r+b. A write with `cfg_sel` = 4 loads `cfg_wdata[0]` as the master enable. A write takes effect from the next cycle.
- R4: Among enabled pending sources, the lowest index wins.
- R5: Acceptance happens only at a clock edge where `instr_last` is 1. `accept` is then high for exactly the following cycle.
- R6: While `accept` is high, `accept_id` is the winner's index and `accept_vec` equals 16'h0003 + 8*`accept_id`. Source 0 gives 16'h0003 and source 23 gives 16'h00BB.
- R7: At acceptance the winner's pending flag is cleared. All other flags keep their values.
- R8: `in_service` rises together with `accept` and stays high until a cycle with `reti` = 1. While it is high, no acceptance occurs and new requests stay pending.
- R9: With `flag_clr_en` = 1, each set bit of `flag_clr_mask` clears the matching flag on the next cycle. A rising request in that same cycle keeps its flag set.
- R10: If a source's request rises in the same cycle that its flag is cleared by acceptance, the flag is 1 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | 24 | Request lines, one per source, edge detected |
| cfg_we | input | 1 | Enable register write strobe |
| cfg_sel | input | 3 | Write target: 0..3 per-source enable group, 4 master enable |
| cfg_wdata | input | 6 | Write data |
| flag_clr_en | input | 1 | Software flag clear strobe |
| flag_clr_mask | input | 24 | Flags to clear |
| instr_last | input | 1 | Final cycle of the current instruction |
| reti | input | 1 | Return-from-interrupt pulse |
| accept | output | 1 | One-cycle acceptance pulse |
| accept_id | output | 5 | Index of the accepted source |
| accept_vec | output | 16 | Service address of the accepted source |
| in_service | output | 1 | A serviced interrupt has not yet returned |
| pending | output | 24 | Latched request flags |

## Verification
The hardest case to reach is a new request for a source arriving on the exact edge where that source is being accepted, so that the flag clear and the flag set land together. The bench first latches the source with a short pulse and lowers the line for one cycle. It then drives `instr_last` and a fresh rising edge on that line at the same falling clock edge. After that, it checks that the accept pulse and the re-set flag appear together. A similar alignment of a software clear with a rising request, and holding a level through a whole service, cover the other edge-detection boundaries.

// File: rtl/vic_pkg.sv
package vic_pkg;
    // Service address of a source: base plus a fixed stride per index.
    function automatic int vic_vec_addr(input int base, input int stride, input int idx);
        return base + stride * idx;
    endfunction
endpackage

// File: rtl/vic_pend_bank.sv
module vic_pend_bank #(
    parameter int N = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);
    typedef struct packed {
        logic [N-1:0] prev;
        logic [N-1:0] pend;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d      = bank_q;
        bank_d.prev = req_i;
        // a rising request beats any clear in the same cycle
        bank_d.pend = (bank_q.pend & ~clr_i) | (req_i & ~bank_q.prev);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign pend_o = bank_q.pend;
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter #(
    parameter int N    = 24,
    parameter int ID_W = 5
) (
    input  logic [N-1:0]    cand_i,
    output logic            found_o,
    output logic [ID_W-1:0] id_o,
    output logic [N-1:0]    onehot_o
);
    always_comb begin
        found_o = 1'b0;
        id_o    = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand_i[i]) begin
                found_o = 1'b1;
                id_o    = ID_W'(i);
            end
        end
        onehot_o = found_o ? (N'(1) << id_o) : '0;
    end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
    parameter int NUM_SRC    = 24,
    parameter int PER_REG    = 6,
    parameter int ADDR_W     = 16,
    parameter int VEC_BASE   = 3,
    parameter int VEC_STRIDE = 8,
    localparam int NUM_REG   = NUM_SRC / PER_REG,
    localparam int SEL_W     = $clog2(NUM_REG + 1),
    localparam int ID_W      = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic               cfg_we,
    input  logic [SEL_W-1:0]   cfg_sel,
    input  logic [PER_REG-1:0] cfg_wdata,
    input  logic               flag_clr_en,
    input  logic [NUM_SRC-1:0] flag_clr_mask,
    input  logic               instr_last,
    input  logic               reti,
    output logic               accept,
    output logic [ID_W-1:0]    accept_id,
    output logic [ADDR_W-1:0]  accept_vec,
    output logic               in_service,
    output logic [NUM_SRC-1:0] pending
);
    import vic_pkg::*;

    typedef struct packed {
        logic [NUM_REG-1:0][PER_REG-1:0] en;
        logic                            ea;
        logic                            isvc;
        logic                            acc;
        logic [ID_W-1:0]                 id;
        logic [ADDR_W-1:0]               vec;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NUM_SRC-1:0] en_flat;
    logic [NUM_SRC-1:0] cand;
    logic [NUM_SRC-1:0] win_hot;
    logic [NUM_SRC-1:0] clr_all;
    logic [ID_W-1:0]    win_id;
    logic               win_found;
    logic               ea_on;
    logic               take;

    assign en_flat = ctl_q.en;
    assign ea_on   = ctl_q.ea;
    assign cand    = pending & en_flat;
    assign take    = instr_last & ea_on & ~ctl_q.isvc & win_found;
    assign clr_all = (take ? win_hot : '0) | (flag_clr_en ? flag_clr_mask : '0);

    vic_pend_bank #(.N(NUM_SRC)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (irq_req),
        .clr_i  (clr_all),
        .pend_o (pending)
    );

    vic_arbiter #(.N(NUM_SRC), .ID_W(ID_W)) u_arb (
        .cand_i   (cand),
        .found_o  (win_found),
        .id_o     (win_id),
        .onehot_o (win_hot)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.acc = take;
        if (cfg_we) begin
            if (int'(cfg_sel) < NUM_REG)
                ctl_d.en[cfg_sel[$clog2(NUM_REG)-1:0]] = cfg_wdata;
            else if (int'(cfg_sel) == NUM_REG)
                ctl_d.ea = cfg_wdata[0];
        end
        if (reti)
            ctl_d.isvc = 1'b0;
        if (take) begin
            ctl_d.isvc = 1'b1;
            ctl_d.id   = win_id;
            ctl_d.vec  = ADDR_W'(vic_vec_addr(VEC_BASE, VEC_STRIDE, int'(win_id)));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign accept     = ctl_q.acc;
    assign accept_id  = ctl_q.id;
    assign accept_vec = ctl_q.vec;
    assign in_service = ctl_q.isvc;
endmodule

// File: rtl/vic_checker.sv
module vic_checker #(
    parameter int N          = 24,
    parameter int ID_W       = 5,
    parameter int ADDR_W     = 16,
    parameter int VEC_BASE   = 3,
    parameter int VEC_STRIDE = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              instr_last,
    input logic              ea_on,
    input logic              accept,
    input logic [ID_W-1:0]   accept_id,
    input logic [ADDR_W-1:0] accept_vec,
    input logic              in_service,
    input logic [N-1:0]      pending
);
    logic [N-1:0] pend_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_prev <= '0;
        else        pend_prev <= pending;
    end

    AST_ACC_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> $past(instr_last)); // R5
    AST_ACC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !accept); // R5
    AST_ACC_MASTER_ON: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> $past(ea_on)); // R3
    AST_VEC_STRIDE: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (int'(accept_vec) == VEC_BASE + VEC_STRIDE * int'(accept_id))); // R6
    AST_WIN_WAS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> pend_prev[accept_id]); // R7
    AST_SVC_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> in_service); // R8
    AST_SVC_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        in_service |=> !accept); // R8
endmodule

bind vec_irq_ctrl vic_checker #(
    .N(NUM_SRC), .ID_W(ID_W), .ADDR_W(ADDR_W),
    .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .instr_last (instr_last),
    .ea_on      (ea_on),
    .accept     (accept),
    .accept_id  (accept_id),
    .accept_vec (accept_vec),
    .in_service (in_service),
    .pending    (pending)
);

// File: tb/sim_vec_irq_ctrl.sv
module sim_vec_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] irq_req = '0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [5:0]  cfg_wdata = '0;
    logic        flag_clr_en = 1'b0;
    logic [23:0] flag_clr_mask = '0;
    logic        instr_last = 1'b0;
    logic        reti = 1'b0;
    logic        accept;
    logic [4:0]  accept_id;
    logic [15:0] accept_vec;
    logic        in_service;
    logic [23:0] pending;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    vec_irq_ctrl u0 (.*);

    // {enable[23:0], master, request[23:0], expect_accept, expect_id[4:0]}
    localparam logic [54:0] TAB [8] = '{
        {24'hFFFFFF, 1'b1, 24'h000006, 1'b1, 5'd1},
        {24'hFFFFFF, 1'b1, 24'h800000, 1'b1, 5'd23},
        {24'hFFFFFE, 1'b1, 24'h000003, 1'b1, 5'd1},
        {24'hFFFFFF, 1'b0, 24'h0000FF, 1'b0, 5'd0},
        {24'h040000, 1'b1, 24'h840001, 1'b1, 5'd18},
        {24'h000000, 1'b1, 24'hFFFFFF, 1'b0, 5'd0},
        {24'h000001, 1'b1, 24'h000001, 1'b1, 5'd0},
        {24'h001000, 1'b1, 24'h003000, 1'b1, 5'd12}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] sel, input logic [5:0] data);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        cyc(1);
        cfg_we = 1'b0;
    endtask

    task automatic set_en(input logic [23:0] en, input logic ea);
        for (int r = 0; r < 4; r++) wr(3'(r), en[6*r +: 6]);
        wr(3'd4, {5'd0, ea});
    endtask

    task automatic flush();
        irq_req = '0; reti = 1'b1; flag_clr_en = 1'b1; flag_clr_mask = '1;
        cyc(1);
        reti = 1'b0; flag_clr_en = 1'b0; flag_clr_mask = '0;
        cyc(1);
    endtask

    task automatic pulse_req(input logic [23:0] m);
        irq_req = m;
        cyc(1);
        irq_req = '0;
    endtask

    task automatic strobe();
        instr_last = 1'b1;
        cyc(1);
        instr_last = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        cyc(2);
        rst_n = 1'b1;
        cyc(1);
        chk("R1 accept", 32'(accept), 0);
        chk("R1 in_service", 32'(in_service), 0);
        chk("R1 pending", 32'(pending), 0);
        // enables cleared by reset: a request must not be accepted
        pulse_req(24'h000001);
        strobe();
        chk("R1 enables off no accept", 32'(accept), 0);
        chk("R2 flag set while disabled", 32'(pending), 32'h1);

        // table walk
        foreach (TAB[i]) begin
            logic [23:0] en, rq, exp_p;
            logic        ea, ea_acc;
            logic [4:0]  eid;
            {en, ea, rq, ea_acc, eid} = TAB[i];
            flush();
            set_en(en, ea);
            pulse_req(rq);
            strobe();
            exp_p = ea_acc ? (rq & ~(24'h1 << eid)) : rq;
            chk($sformatf("R3 R4 R5 vector %0d accept", i), 32'(accept), 32'(ea_acc));
            if (ea_acc) begin
                chk($sformatf("R4 vector %0d id", i), 32'(accept_id), 32'(eid));
                chk($sformatf("R6 vector %0d address", i), 32'(accept_vec), 32'h3 + 32'(eid) * 8);
            end
            chk($sformatf("R7 vector %0d pending", i), 32'(pending), 32'(exp_p));
        end

        // R5: no acceptance without the instruction-boundary strobe
        flush();
        set_en(24'hFFFFFF, 1'b1);
        pulse_req(24'h000020);
        cyc(3);
        chk("R5 no strobe no accept", 32'(accept), 0);
        chk("R5 flag still pending", 32'(pending), 32'h20);
        strobe();
        chk("R5 strobe accept", 32'(accept), 1);
        chk("R5 id", 32'(accept_id), 5);
        cyc(1);
        chk("R5 single-cycle pulse", 32'(accept), 0);

        // R8: in service blocks further acceptance
        pulse_req(24'h000004);
        strobe();
        chk("R8 blocked accept", 32'(accept), 0);
        chk("R8 in_service held", 32'(in_service), 1);
        chk("R8 request kept pending", 32'(pending), 32'h4);
        reti = 1'b1; cyc(1); reti = 1'b0;
        chk("R8 reti clears service", 32'(in_service), 0);
        strobe();
        chk("R8 accept after return", 32'(accept), 1);
        chk("R8 id after return", 32'(accept_id), 2);

        // R2: a held level sets the flag only once
        flush();
        irq_req = 24'h000080;
        cyc(2);
        strobe();
        chk("R2 level accept", 32'(accept_id), 7);
        reti = 1'b1; cyc(1); reti = 1'b0;
        strobe();
        chk("R2 held level no second accept", 32'(accept), 0);
        chk("R2 held level no flag", 32'(pending), 0);
        irq_req = '0;
        cyc(1);

        // R9: software clear, and rising request winning over the clear
        pulse_req(24'h000200);
        chk("R9 flag before clear", 32'(pending), 32'h200);
        flag_clr_en = 1'b1; flag_clr_mask = 24'h000200;
        cyc(1);
        flag_clr_en = 1'b0; flag_clr_mask = '0;
        chk("R9 cleared", 32'(pending), 0);
        strobe();
        chk("R9 cleared not accepted", 32'(accept), 0);
        set_en(24'h0, 1'b1);
        irq_req = 24'h000010; flag_clr_en = 1'b1; flag_clr_mask = 24'h000010;
        cyc(1);
        irq_req = '0; flag_clr_en = 1'b0; flag_clr_mask = '0;
        chk("R9 rise beats clear", 32'(pending), 32'h10);

        // R10: re-arrival on the accepting edge
        flush();
        set_en(24'hFFFFFF, 1'b1);
        pulse_req(24'h000008);
        cyc(1);
        irq_req = 24'h000008; instr_last = 1'b1;
        cyc(1);
        irq_req = '0; instr_last = 1'b0;
        chk("R10 accept", 32'(accept), 1);
        chk("R10 id", 32'(accept_id), 3);
        chk("R10 flag set again", 32'(pending), 32'h8);
        reti = 1'b1; cyc(1); reti = 1'b0;
        strobe();
        chk("R10 second accept", 32'(accept_id), 3);
        chk("R10 second accept pulse", 32'(accept), 1);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule